// File: doc/BRIEF.md
# Quadrature Position Counter with Index

This block turns the two phase lines of an incremental encoder into a 32-bit up/down position count. Every edge on either phase line moves the count by one, which gives four counts per encoder cycle. The direction comes from which phase leads. The phase lines and the index line are first brought into the system clock domain through a two-stage synchronizer. Edges are then detected on the synchronized copies.

The index line has two roles. The first is a start trigger. After an arm request, the counter sits at a programmable reload value and ignores motion. The first rising index edge then releases it, so several counters wired to the same index begin together. The second role is range limiting. When index reload is switched on, every rising index edge puts the count back to the reload value. The count then stays inside one revolution's worth of counts and does not wrap. With index reload off, the counter runs free, and a one-clock flag marks each wrap through the terminal value. A step in which both phase lines change in the same sample cannot be decoded. Such a step leaves the count alone and raises a sticky error flag.

Top module: `qpos_counter`

## Requirements
- R1: After reset, `count` is 0 and `rollover`, `armed` and `quad_err` are all 0.
- R2: With `{quad_a,quad_b}` stepping 00→10→11→01→00 (A leads B), each step raises `count` by exactly one, so one encoder cycle gives four counts.
- R3: With `{quad_a,quad_b}` stepping 00→01→11→10→00 (B leads A), each step lowers `count` by exactly one, wrapping in two's complement.
- R4: A sample in which both `quad_a` and `quad_b` change leaves `count` unchanged and sets `quad_err`. `quad_err` then stays 1 until reset, and later legal steps count from the new phase.
- R5: While `index_reload_en` is 1 and `enable` is 1, a rising edge on `quad_z` loads `reload_val` into `count`.
- R6: While `index_reload_en` is 0 and the block is not armed, `quad_z` has no effect on `count`.
- R7: A one-cycle `arm` pulse sets `armed` at the next clock edge. While armed, `count` follows `reload_val` and phase steps are ignored. The next rising `quad_z` edge clears `armed` and leaves `count` at `reload_val`, whatever the setting of `index_reload_en`. Counting resumes from that value.
- R8: With `index_reload_en` at 0, a step up from 0xFFFFFFFF to 0, or a step down from 0 to 0xFFFFFFFF, raises `rollover` for exactly one clock. Steps that do not wrap leave `rollover` at 0.
- R9: While `enable` is 0, phase steps and index edges leave `count` unchanged. When `enable` returns to 1, counting continues from the current phase without a spurious step.
- R10: A phase change sampled at one clock edge shows up in `count` after the third rising clock edge. At the first and second edges, `count` still holds its old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Allows counting and index reload |
| arm | input | 1 | One-cycle request to wait for the next index edge |
| index_reload_en | input | 1 | Reload the count on every rising index edge |
| reload_val | input | 32 | Value loaded on index reload and held while armed |
| quad_a | input | 1 | Encoder phase A, asynchronous |
| quad_b | input | 1 | Encoder phase B, asynchronous |
| quad_z | input | 1 | Encoder index, asynchronous |
| count | output | 32 | Position count, two's complement |
| rollover | output | 1 | One-clock pulse on a free-running wrap |
| armed | output | 1 | High while waiting for the index edge |
| quad_err | output | 1 | Sticky flag for an illegal double-phase change |

## Verification
The in-line properties assume that `reload_val` is stable whenever an index edge or an arm request can load it. They also assume that a wrap in one direction is never followed, on the very next clock, by a wrap in the other direction. The stimulus changes the phase and index lines only on falling clock edges. After every change it waits five clocks, so each synchronized edge settles before the next one. `reload_val` and the control inputs are changed only between these settled windows, so no load ever catches a value in motion.

// File: rtl/qpos_pkg.sv
package qpos_pkg;

  typedef enum logic [1:0] {
    STEP_NONE = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DOWN = 2'd2,
    STEP_BAD  = 2'd3
  } step_e;

  // prev/cur are {A,B}. Forward phase order: 00 -> 10 -> 11 -> 01 -> 00.
  function automatic step_e quad_step(input logic [1:0] prev, input logic [1:0] cur);
    logic [1:0] diff;
    diff = prev ^ cur;
    if (diff == 2'b00) return STEP_NONE;
    if (diff == 2'b11) return STEP_BAD;
    case ({prev, cur})
      4'b0010, 4'b1011, 4'b1101, 4'b0100: return STEP_UP;
      default:                            return STEP_DOWN;
    endcase
  endfunction

endpackage

// File: rtl/qpos_sync.sv
module qpos_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  logic [WIDTH-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[s] <= '0;
          else        stage_q[s] <= async_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[s] <= '0;
          else        stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/qpos_decode.sv
module qpos_decode
  import qpos_pkg::*;
#(
  parameter int PRIME = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] ab_i,
  input  logic       z_i,
  output step_e      step_o,
  output logic       idx_rise_o
);

  logic [1:0]     prev_ab_q;
  logic           prev_z_q;
  logic [PRIME:0] fill_q;
  logic           live;

  // Edges are decoded only once the synchronizer holds real samples.
  assign live = fill_q[PRIME];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_ab_q <= 2'b00;
      prev_z_q  <= 1'b0;
      fill_q    <= '0;
    end else begin
      prev_ab_q <= ab_i;
      prev_z_q  <= z_i;
      fill_q    <= {fill_q[PRIME-1:0], 1'b1};
    end
  end

  assign step_o     = live ? quad_step(prev_ab_q, ab_i) : STEP_NONE;
  assign idx_rise_o = live & z_i & ~prev_z_q;

  // A rising edge needs a low sample first, so it never lasts two cycles.
  assert_index_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    idx_rise_o |=> !idx_rise_o);

endmodule

// File: rtl/qpos_core.sv
module qpos_core
  import qpos_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable_i,
  input  logic             arm_i,
  input  logic             reload_en_i,
  input  logic [CNT_W-1:0] reload_val_i,
  input  step_e            step_i,
  input  logic             idx_rise_i,
  output logic [CNT_W-1:0] count_o,
  output logic             roll_o,
  output logic             armed_o,
  output logic             err_o
);

  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  // Returns {wrap, next}.
  function automatic logic [CNT_W:0] advance(input logic [CNT_W-1:0] c, input logic up);
    if (up) return {&c, c + ONE};
    else    return {~|c, c - ONE};
  endfunction

  logic [CNT_W-1:0] count_q, count_n;
  logic             armed_q, armed_n;
  logic             roll_q, roll_n;
  logic             err_q, err_n;
  logic             load_ev;
  logic             move_ev;
  logic [CNT_W:0]   adv;

  assign move_ev = (step_i == STEP_UP) || (step_i == STEP_DOWN);
  assign adv     = advance(count_q, step_i == STEP_UP);

  always_comb begin
    count_n = count_q;
    armed_n = armed_q;
    roll_n  = 1'b0;
    load_ev = 1'b0;
    if (arm_i) begin
      armed_n = 1'b1;
      count_n = reload_val_i;
      load_ev = 1'b1;
    end else if (armed_q) begin
      count_n = reload_val_i;
      load_ev = 1'b1;
      if (idx_rise_i) armed_n = 1'b0;
    end else if (enable_i) begin
      if (idx_rise_i && reload_en_i) begin
        count_n = reload_val_i;
        load_ev = 1'b1;
      end else if (move_ev) begin
        count_n = adv[CNT_W-1:0];
        roll_n  = adv[CNT_W] & ~reload_en_i;
      end
    end
  end

  assign err_n = err_q | (step_i == STEP_BAD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      armed_q <= 1'b0;
      roll_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      count_q <= count_n;
      armed_q <= armed_n;
      roll_q  <= roll_n;
      err_q   <= err_n;
    end
  end

  assign count_o = count_q;
  assign roll_o  = roll_q;
  assign armed_o = armed_q;
  assign err_o   = err_q;

  assert_step_unit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(load_ev) |-> ((count_q == $past(count_q)) ||
                         (count_q == $past(count_q) + ONE) ||
                         (count_q == $past(count_q) - ONE)));

  assert_err_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q);

  assert_bad_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i == STEP_BAD && !arm_i && !armed_q && !(idx_rise_i && reload_en_i))
      |=> $stable(count_q));

  assert_armed_tracks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q |-> (count_q == $past(reload_val_i)));

  assert_roll_free_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
    roll_q |-> !$past(reload_en_i));

  assert_disabled_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable_i && !arm_i && !armed_q) |=> $stable(count_q));

endmodule

// File: rtl/qpos_counter.sv
module qpos_counter
  import qpos_pkg::*;
#(
  parameter int CNT_W       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             arm,
  input  logic             index_reload_en,
  input  logic [CNT_W-1:0] reload_val,
  input  logic             quad_a,
  input  logic             quad_b,
  input  logic             quad_z,
  output logic [CNT_W-1:0] count,
  output logic             rollover,
  output logic             armed,
  output logic             quad_err
);

  localparam int LINES = 3;

  logic [LINES-1:0] lines_sync;
  step_e            step;
  logic             idx_rise;

  qpos_sync #(.WIDTH(LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .async_i({quad_z, quad_a, quad_b}),
    .sync_o (lines_sync)
  );

  qpos_decode #(.PRIME(SYNC_STAGES)) u_decode (
    .clk       (clk),
    .rst_n     (rst_n),
    .ab_i      (lines_sync[1:0]),
    .z_i       (lines_sync[2]),
    .step_o    (step),
    .idx_rise_o(idx_rise)
  );

  qpos_core #(.CNT_W(CNT_W)) u_core (
    .clk         (clk),
    .rst_n       (rst_n),
    .enable_i    (enable),
    .arm_i       (arm),
    .reload_en_i (index_reload_en),
    .reload_val_i(reload_val),
    .step_i      (step),
    .idx_rise_i  (idx_rise),
    .count_o     (count),
    .roll_o      (rollover),
    .armed_o     (armed),
    .err_o       (quad_err)
  );

endmodule

// File: tb/qpos_counter_bench.sv
module qpos_counter_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic        arm = 1'b0;
  logic        index_reload_en = 1'b0;
  logic [31:0] reload_val = '0;
  logic        quad_a = 1'b0;
  logic        quad_b = 1'b0;
  logic        quad_z = 1'b0;
  logic [31:0] count;
  logic        rollover;
  logic        armed;
  logic        quad_err;

  int n_chk = 0;
  int n_bad = 0;
  int roll_seen = 0;
  logic [1:0]  ab = 2'b00;
  logic [31:0] exp_cnt = '0;

  always #2 clk = ~clk;

  qpos_counter u_qpos_counter (
    .clk(clk), .rst_n(rst_n), .enable(enable), .arm(arm),
    .index_reload_en(index_reload_en), .reload_val(reload_val),
    .quad_a(quad_a), .quad_b(quad_b), .quad_z(quad_z),
    .count(count), .rollover(rollover), .armed(armed), .quad_err(quad_err)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [1:0] fwd(input logic [1:0] p);
    case (p)
      2'b00: return 2'b10;
      2'b10: return 2'b11;
      2'b11: return 2'b01;
      default: return 2'b00;
    endcase
  endfunction

  function automatic logic [1:0] rev(input logic [1:0] p);
    case (p)
      2'b00: return 2'b01;
      2'b01: return 2'b11;
      2'b11: return 2'b10;
      default: return 2'b00;
    endcase
  endfunction

  task automatic drive_ab(input logic [1:0] v);
    @(negedge clk);
    quad_a = v[1];
    quad_b = v[0];
    ab = v;
    roll_seen = 0;
    repeat (5) begin
      @(negedge clk);
      if (rollover) roll_seen++;
    end
  endtask

  task automatic go_up();   drive_ab(fwd(ab)); endtask
  task automatic go_down(); drive_ab(rev(ab)); endtask

  task automatic pulse_z();
    @(negedge clk); quad_z = 1'b1;
    repeat (5) @(negedge clk);
    quad_z = 1'b0;
    repeat (5) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 count", count, 32'd0);
    chk("R1 flags", {29'd0, rollover, armed, quad_err}, 32'd0);
  endtask

  task automatic t_latency_up();
    @(negedge clk); quad_a = 1'b1; ab = 2'b10;
    @(negedge clk); chk("R10 edge1", count, 32'd0);
    @(negedge clk); chk("R10 edge2", count, 32'd0);
    @(negedge clk); chk("R10 edge3", count, 32'd1);
    repeat (3) @(negedge clk);
    for (int i = 0; i < 7; i++) go_up();
    chk("R2 two cycles up", count, 32'd8);
  endtask

  task automatic t_down();
    for (int i = 0; i < 12; i++) go_down();
    chk("R3 down to -4", count, 32'hFFFF_FFFC);
    chk("R3 no rollover", roll_seen, 0);
  endtask

  task automatic t_illegal();
    drive_ab(~ab);
    chk("R4 count held", count, 32'hFFFF_FFFC);
    chk("R4 err set", quad_err, 1'b1);
    go_up();
    chk("R4 counts on", count, 32'hFFFF_FFFD);
    chk("R4 err sticky", quad_err, 1'b1);
  endtask

  task automatic t_index_reload();
    reload_val = 32'd100;
    index_reload_en = 1'b1;
    pulse_z();
    chk("R5 reload", count, 32'd100);
    go_down();
    chk("R5 after step", count, 32'd99);
  endtask

  task automatic t_no_reload();
    index_reload_en = 1'b0;
    reload_val = 32'd5;
    pulse_z();
    chk("R6 index ignored", count, 32'd99);
  endtask

  task automatic t_enable();
    @(negedge clk); enable = 1'b0;
    for (int i = 0; i < 3; i++) go_up();
    index_reload_en = 1'b1;
    pulse_z();
    chk("R9 held", count, 32'd99);
    index_reload_en = 1'b0;
    @(negedge clk); enable = 1'b1;
    repeat (3) @(negedge clk);
    chk("R9 no jump", count, 32'd99);
    go_up();
    chk("R9 resumes", count, 32'd100);
  endtask

  task automatic t_arm();
    reload_val = 32'd7;
    @(negedge clk); arm = 1'b1;
    @(negedge clk); arm = 1'b0;
    chk("R7 armed", armed, 1'b1);
    chk("R7 at reload", count, 32'd7);
    go_up(); go_up();
    chk("R7 steps ignored", count, 32'd7);
    reload_val = 32'd9;
    repeat (2) @(negedge clk);
    chk("R7 follows reload", count, 32'd9);
    pulse_z();
    chk("R7 released", armed, 1'b0);
    chk("R7 start value", count, 32'd9);
    go_up();
    chk("R7 counting", count, 32'd10);
  endtask

  task automatic t_rollover();
    reload_val = 32'hFFFF_FFFF;
    index_reload_en = 1'b1;
    pulse_z();
    chk("R8 preset", count, 32'hFFFF_FFFF);
    index_reload_en = 1'b0;
    go_up();
    chk("R8 wrap up", count, 32'd0);
    chk("R8 one pulse up", roll_seen, 1);
    go_down();
    chk("R8 wrap down", count, 32'hFFFF_FFFF);
    chk("R8 one pulse down", roll_seen, 1);
    go_down();
    chk("R8 plain step", roll_seen, 0);
    chk("R8 count", count, 32'hFFFF_FFFE);
  endtask

  initial begin
    #(4 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    enable = 1'b1;
    t_latency_up();
    t_down();
    t_illegal();
    t_index_reload();
    t_no_reload();
    t_enable();
    t_arm();
    t_rollover();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule